// File: doc/BRIEF.md
# 2D DMA Descriptor Sequencer

This block runs one DMA channel from descriptors held in word-addressed memory. Software loads a starting descriptor address and enables the channel. From then on, each trigger pulse releases a configured amount of work. The channel reads a descriptor, walks nested X (inner) and Y (outer) loops, and moves one element per iteration. Each element is one read followed by one write, with an element size of 8, 16 or 32 bits. Descriptor reads and data moves share a single valid/ready request port, which carries one read response per read.

Each descriptor sets three granularities on its own: how much work one trigger releases, when the trigger-out pulse fires, and when the interrupt pulse fires. The choices are element, row, descriptor or whole chain. The loop position is kept between triggers. Descriptors can be chained through a next pointer, and the chain may be circular. A descriptor can also turn its own channel off once it completes.

Top module: `dma_seq`

## Requirements
- R1: After reset, `ch_en_o`, `req_valid_o`, `tr_out_o` and `irq_o` are all low.
- R2: A descriptor at address P is read as 32-bit words at P, P+4, P+8 and so on. The word order is control, source, destination, X word, Y word, next pointer. Single descriptors omit both loop words (4 words). 1D descriptors omit the Y word (5 words). 2D descriptors use all 6 words.
- R3: Control word fields:
  - bits [1:0] kind: 0 single, 1 1D, 2 or 3 2D.
  - bits [3:2] element size: 0 byte, 1 half, 2 word. This is driven on `req_size_o`.
  - bits [5:4] trigger-in granularity.
  - bits [7:6] trigger-out granularity.
  - bits [9:8] interrupt granularity.
  - bit 10: disable the channel after this descriptor.
  - Granularity codes: 0 element, 1 row, 2 descriptor, 3 chain.
- R4: The X and Y words each hold a count in [7:0] (iterations minus one), a source increment in [15:8] and a destination increment in [23:16]. Element addresses are base + ((x*incX + y*incY) << size), computed separately for source and destination.
- R5: Each element is one read of the source followed by one write to the destination. The write carries the read data and uses the same size. A request holds its address, direction and data until `req_ready_i` is high.
- R6: A trigger releases work up to the end of its granularity unit:
  - code 0: one element;
  - code 1: to the end of the current row;
  - code 2: to the end of the current descriptor;
  - code 3: to the end of the chain.
- R7: `tr_out_o` and `irq_o` each give a one-cycle pulse at the end of every unit of their own granularity.
- R8: A non-zero next pointer makes the following descriptor the current one. A zero next pointer ends the chain: the same descriptor is fetched again on the next trigger, starting from index zero.
- R9: When the disable bit is set, `ch_en_o` drops once that descriptor completes, and the channel stops.
- R10: A trigger arriving while the channel is busy or disabled is ignored.
- R11: The X and Y indices persist across triggers, so each trigger continues from where the previous one stopped.
- R12: `en_set_i`, when the channel is idle, loads `ptr_i` as the current descriptor, sets both indices to zero and raises `ch_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| en_set_i | input | 1 | load pointer and enable channel |
| ptr_i | input | AW | first descriptor address |
| trig_i | input | 1 | trigger pulse |
| ch_en_o | output | 1 | channel enabled |
| req_valid_o | output | 1 | bus request valid |
| req_ready_i | input | 1 | bus request accepted |
| req_write_o | output | 1 | 1 write, 0 read |
| req_addr_o | output | AW | byte address |
| req_size_o | output | 2 | 0 byte, 1 half, 2 word |
| req_wdata_o | output | 32 | write data |
| rsp_valid_i | input | 1 | read data valid |
| rsp_rdata_i | input | 32 | read data |
| tr_out_o | output | 1 | trigger-out pulse |
| irq_o | output | 1 | interrupt pulse |

## Verification
A wrong loop index shows up on the very next write as a destination address off by one increment. It also moves a whole row of pulses, because the row-end and descriptor-end decisions come from the same counters. A corrupted stop decision shows as a wrong number of writes after one trigger: either too few, or a run that keeps going into elements of the next unit. Faults in descriptor parsing appear on the first element as a wrong base address, size or word count. The bench compares every write and counts the pulses after each trigger.

// File: rtl/dma_seq_pkg.sv
`timescale 1ns/1ps
package dma_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DREQ, ST_DRSP, ST_RREQ, ST_RRSP, ST_WREQ, ST_STEP
  } st_e;

  typedef enum logic [1:0] {GR_ELEM, GR_ROW, GR_DESC, GR_CHAIN} gran_e;
  typedef enum logic [1:0] {K_SINGLE, K_1D, K_2D, K_2D_ALT} kind_e;

  typedef struct packed {
    logic  ch_off;
    gran_e irq_g;
    gran_e out_g;
    gran_e in_g;
    logic [1:0] size;
    kind_e kind;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

  // index of the next-pointer word for a kind
  function automatic logic [2:0] last_word(kind_e k);
    case (k)
      K_SINGLE: return 3'd3;
      K_1D:     return 3'd4;
      default:  return 3'd5;
    endcase
  endfunction

  function automatic logic gran_hit(gran_e g, logic row, logic desc, logic chain);
    case (g)
      GR_ELEM: return 1'b1;
      GR_ROW:  return row;
      GR_DESC: return desc;
      default: return chain;
    endcase
  endfunction

endpackage

// File: rtl/dma_seq_agen.sv
`timescale 1ns/1ps
module dma_seq_agen #(
  parameter int AW = 32,
  parameter int CW = 8,
  parameter int IW = 8
) (
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] x_i,
  input  logic [CW-1:0] y_i,
  input  logic [IW-1:0] xinc_i,
  input  logic [IW-1:0] yinc_i,
  input  logic [1:0]    size_i,
  output logic [AW-1:0] addr_o
);
  localparam int PW = CW + IW;
  localparam int SW = PW + 4;

  logic [PW-1:0] xp, yp;
  logic [PW:0]   offs;
  logic [SW-1:0] scaled;

  always_comb begin
    xp     = PW'(x_i) * PW'(xinc_i);
    yp     = PW'(y_i) * PW'(yinc_i);
    offs   = (PW+1)'(xp) + (PW+1)'(yp);
    scaled = SW'(offs) << size_i;
    addr_o = base_i + AW'(scaled);
  end
endmodule

// File: rtl/dma_seq_loop.sv
`timescale 1ns/1ps
module dma_seq_loop
  import dma_seq_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          step_i,
  input  kind_e         kind_i,
  input  logic [CW-1:0] xcnt_i,
  input  logic [CW-1:0] ycnt_i,
  output logic [CW-1:0] x_o,
  output logic [CW-1:0] y_o,
  output logic          row_end_o,
  output logic          desc_end_o
);
  logic [CW-1:0] x_q, y_q;

  assign row_end_o  = (kind_i == K_SINGLE) || (x_q == xcnt_i);
  assign desc_end_o = row_end_o &&
                      ((kind_i == K_SINGLE) || (kind_i == K_1D) || (y_q == ycnt_i));
  assign x_o = x_q;
  assign y_o = y_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q <= '0;
      y_q <= '0;
    end else if (clr_i) begin
      x_q <= '0;
      y_q <= '0;
    end else if (step_i) begin
      if (!row_end_o) begin
        x_q <= x_q + 1'b1;
      end else begin
        x_q <= '0;
        y_q <= desc_end_o ? '0 : y_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_seq_pulse.sv
`timescale 1ns/1ps
module dma_seq_pulse
  import dma_seq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  fire_i,
  input  gran_e gran_i,
  input  logic  row_i,
  input  logic  desc_i,
  input  logic  chain_i,
  output logic  pulse_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_o <= 1'b0;
    else         pulse_o <= fire_i && gran_hit(gran_i, row_i, desc_i, chain_i);
  end
endmodule

// File: rtl/dma_seq.sv
`timescale 1ns/1ps
module dma_seq
  import dma_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 8,
  parameter int IW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_set_i,
  input  logic [AW-1:0] ptr_i,
  input  logic          trig_i,
  output logic          ch_en_o,
  output logic          req_valid_o,
  input  logic          req_ready_i,
  output logic          req_write_o,
  output logic [AW-1:0] req_addr_o,
  output logic [1:0]    req_size_o,
  output logic [31:0]   req_wdata_o,
  input  logic          rsp_valid_i,
  input  logic [31:0]   rsp_rdata_i,
  output logic          tr_out_o,
  output logic          irq_o
);
  localparam int LW = CW + 2*IW;

  st_e           st_q;
  logic          en_q, dv_q;
  logic [AW-1:0] ptr_q, src_q, dst_q, nxt_q;
  ctl_t          ctl_q;
  logic [LW-1:0] xw_q, yw_q;
  logic [31:0]   data_q;
  logic [2:0]    widx_q;

  logic [CW-1:0] x_cur, y_cur;
  logic          row_end, desc_end, chain_end, step, stop, load;
  logic [AW-1:0] addr_w [2];
  logic [AW-1:0] base_w [2];
  logic          pulse_w [2];
  gran_e         gsel_w [2];

  assign step      = (st_q == ST_STEP);
  assign load      = (st_q == ST_IDLE) && en_set_i;
  assign chain_end = desc_end && (nxt_q == '0);
  assign stop      = gran_hit(ctl_q.in_g, row_end, desc_end, chain_end) ||
                     chain_end || (desc_end && ctl_q.ch_off);

  dma_seq_loop #(.CW(CW)) u_loop (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (load),
    .step_i     (step),
    .kind_i     (ctl_q.kind),
    .xcnt_i     (xw_q[CW-1:0]),
    .ycnt_i     (yw_q[CW-1:0]),
    .x_o        (x_cur),
    .y_o        (y_cur),
    .row_end_o  (row_end),
    .desc_end_o (desc_end)
  );

  assign base_w[0] = src_q;
  assign base_w[1] = dst_q;
  assign gsel_w[0] = ctl_q.out_g;
  assign gsel_w[1] = ctl_q.irq_g;

  for (genvar g = 0; g < 2; g++) begin : g_side
    // g=0 source, g=1 destination
    dma_seq_agen #(.AW(AW), .CW(CW), .IW(IW)) u_agen (
      .base_i (base_w[g]),
      .x_i    (x_cur),
      .y_i    (y_cur),
      .xinc_i (xw_q[CW+g*IW +: IW]),
      .yinc_i (yw_q[CW+g*IW +: IW]),
      .size_i (ctl_q.size),
      .addr_o (addr_w[g])
    );
    // g=0 trigger out, g=1 interrupt
    dma_seq_pulse u_pulse (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .fire_i  (step),
      .gran_i  (gsel_w[g]),
      .row_i   (row_end),
      .desc_i  (desc_end),
      .chain_i (chain_end),
      .pulse_o (pulse_w[g])
    );
  end

  assign tr_out_o = pulse_w[0];
  assign irq_o    = pulse_w[1];
  assign ch_en_o  = en_q;

  always_comb begin
    req_valid_o = (st_q == ST_DREQ) || (st_q == ST_RREQ) || (st_q == ST_WREQ);
    req_write_o = (st_q == ST_WREQ);
    req_wdata_o = data_q;
    req_size_o  = ctl_q.size;
    unique case (st_q)
      ST_DREQ: begin
        req_addr_o = ptr_q + AW'({widx_q, 2'b00});
        req_size_o = 2'd2;
      end
      ST_WREQ: req_addr_o = addr_w[1];
      default: req_addr_o = addr_w[0];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      en_q   <= 1'b0;
      dv_q   <= 1'b0;
      ptr_q  <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      nxt_q  <= '0;
      ctl_q  <= '0;
      xw_q   <= '0;
      yw_q   <= '0;
      data_q <= '0;
      widx_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (en_set_i) begin
            ptr_q <= ptr_i;
            en_q  <= 1'b1;
            dv_q  <= 1'b0;
          end else if (trig_i && en_q) begin
            if (dv_q) begin
              st_q <= ST_RREQ;
            end else begin
              widx_q <= '0;
              st_q   <= ST_DREQ;
            end
          end
        end
        ST_DREQ: if (req_ready_i) st_q <= ST_DRSP;
        ST_DRSP: begin
          if (rsp_valid_i) begin
            case (widx_q)
              3'd0: begin
                ctl_q <= ctl_t'(rsp_rdata_i[CTL_W-1:0]);
                xw_q  <= '0;
                yw_q  <= '0;
              end
              3'd1: src_q <= rsp_rdata_i[AW-1:0];
              3'd2: dst_q <= rsp_rdata_i[AW-1:0];
              default: begin
                if (widx_q == last_word(ctl_q.kind)) nxt_q <= rsp_rdata_i[AW-1:0];
                else if (widx_q == 3'd3)            xw_q  <= rsp_rdata_i[LW-1:0];
                else                                 yw_q  <= rsp_rdata_i[LW-1:0];
              end
            endcase
            if (widx_q != 3'd0 && widx_q == last_word(ctl_q.kind)) begin
              dv_q <= 1'b1;
              st_q <= ST_RREQ;
            end else begin
              widx_q <= widx_q + 1'b1;
              st_q   <= ST_DREQ;
            end
          end
        end
        ST_RREQ: if (req_ready_i) st_q <= ST_RRSP;
        ST_RRSP: begin
          if (rsp_valid_i) begin
            data_q <= rsp_rdata_i;
            st_q   <= ST_WREQ;
          end
        end
        ST_WREQ: if (req_ready_i) st_q <= ST_STEP;
        ST_STEP: begin
          if (desc_end) begin
            dv_q <= 1'b0;
            if (nxt_q != '0) ptr_q <= nxt_q;
            if (ctl_q.ch_off) en_q <= 1'b0;
          end
          if (stop) begin
            st_q <= ST_IDLE;
          end else if (desc_end) begin
            widx_q <= '0;
            st_q   <= ST_DREQ;
          end else begin
            st_q <= ST_RREQ;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_seq_chk.sv
`timescale 1ns/1ps
module dma_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ch_en_o,
  input logic          req_valid_o,
  input logic          req_ready_i,
  input logic          req_write_o,
  input logic [AW-1:0] req_addr_o,
  input logic [31:0]   req_wdata_o,
  input logic          rsp_valid_i,
  input logic [31:0]   rsp_rdata_i,
  input logic          tr_out_o,
  input logic          irq_o
);
  logic        rd_pend;
  logic [31:0] last_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_pend <= 1'b0;
      last_rd <= '0;
    end else begin
      if (req_valid_o && req_ready_i && !req_write_o) rd_pend <= 1'b1;
      else if (rsp_valid_i)                           rd_pend <= 1'b0;
      if (rsp_valid_i && rd_pend) last_rd <= rsp_rdata_i;
    end
  end

  // R5
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o) &&
    $stable(req_write_o) && $stable(req_wdata_o));

  // R5
  wdata_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && req_write_o |-> req_wdata_o == last_rd);

  // R7
  tr_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tr_out_o |=> !tr_out_o);

  // R7
  irq_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  // R10
  off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ch_en_o |-> !req_valid_o);

  // R12
  en_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ch_en_o) |-> !req_valid_o);
endmodule

bind dma_seq dma_seq_chk #(.AW(AW)) u_chk (.*);

// File: tb/dma_seq_test.sv
`timescale 1ns/1ps
module dma_seq_test;
  logic clk = 1'b0, rst_n = 1'b0, en_set = 1'b0, trig = 1'b0;
  logic req_ready = 1'b0, rsp_valid = 1'b0;
  logic [31:0] ptr = '0, rsp_rdata = '0;
  logic ch_en, req_valid, req_write, tr_out, irq;
  logic [31:0] req_addr, req_wdata;
  logic [1:0] req_size;

  always #2.5 clk = ~clk;

  dma_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .en_set_i(en_set), .ptr_i(ptr), .trig_i(trig),
    .ch_en_o(ch_en), .req_valid_o(req_valid), .req_ready_i(req_ready),
    .req_write_o(req_write), .req_addr_o(req_addr), .req_size_o(req_size),
    .req_wdata_o(req_wdata), .rsp_valid_i(rsp_valid), .rsp_rdata_i(rsp_rdata),
    .tr_out_o(tr_out), .irq_o(irq)
  );

  logic [31:0] dmem [256];
  logic [31:0] exp_addr [4096];
  logic [31:0] exp_data [4096];
  logic [1:0]  exp_size [4096];
  int exp_n, wr_idx, exp_tr, exp_irq, tr_cnt, irq_cnt, n_chk, n_fail;
  bit rsp_busy;

  // model state
  bit m_en, m_dv;
  logic [31:0] m_ptr;
  int m_x, m_y;
  int d_kind, d_sz, d_tin, d_tout, d_irq, d_off;
  logic [31:0] d_src, d_dst, d_xw, d_yw, d_nxt;

  function automatic logic [31:0] hash(logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  function automatic bit hit(int g, bit r, bit d, bit c);
    case (g)
      0: return 1'b1;
      1: return r;
      2: return d;
      default: return c;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  // R2 R3: word layout depends on kind
  task automatic put_desc(input int b, input int kind, input int sz, input int tin,
                          input int tout, input int ir, input int off,
                          input logic [31:0] src, input logic [31:0] dst,
                          input int xc, input int sxi, input int dxi,
                          input int yc, input int syi, input int dyi,
                          input logic [31:0] nxt);
    int k = b >> 2;
    dmem[k]   = 32'(kind | (sz << 2) | (tin << 4) | (tout << 6) | (ir << 8) | (off << 10));
    dmem[k+1] = src;
    dmem[k+2] = dst;
    k += 3;
    if (kind != 0) begin dmem[k] = 32'(xc | (sxi << 8) | (dxi << 16)); k++; end
    if (kind >= 2) begin dmem[k] = 32'(yc | (syi << 8) | (dyi << 16)); k++; end
    dmem[k] = nxt;
  endtask

  task automatic model_trig();
    bit stop, r, d, c;
    int guard = 0;
    int k;
    logic [31:0] sa, da;
    if (!m_en) return;
    do begin
      if (!m_dv) begin
        k = int'(m_ptr >> 2);
        d_kind = int'(dmem[k][1:0]); d_sz = int'(dmem[k][3:2]);
        d_tin = int'(dmem[k][5:4]);  d_tout = int'(dmem[k][7:6]);
        d_irq = int'(dmem[k][9:8]);  d_off = int'(dmem[k][10]);
        d_src = dmem[k+1]; d_dst = dmem[k+2]; d_xw = 0; d_yw = 0;
        k += 3;
        if (d_kind != 0) begin d_xw = dmem[k]; k++; end
        if (d_kind >= 2) begin d_yw = dmem[k]; k++; end
        d_nxt = dmem[k];
        m_dv = 1;
      end
      sa = d_src + ((32'(m_x) * d_xw[15:8] + 32'(m_y) * d_yw[15:8]) << d_sz);
      da = d_dst + ((32'(m_x) * d_xw[23:16] + 32'(m_y) * d_yw[23:16]) << d_sz);
      exp_addr[exp_n] = da; exp_size[exp_n] = 2'(d_sz); exp_data[exp_n] = hash(sa);
      exp_n++;
      r = (d_kind == 0) || (m_x == int'(d_xw[7:0]));
      d = r && (d_kind < 2 || m_y == int'(d_yw[7:0]));
      c = d && (d_nxt == 0);
      if (hit(d_tout, r, d, c)) exp_tr++;
      if (hit(d_irq, r, d, c)) exp_irq++;
      stop = hit(d_tin, r, d, c) || c || (d && d_off != 0);
      if (!r) m_x++;
      else begin m_x = 0; m_y = d ? 0 : m_y + 1; end
      if (d) begin
        m_dv = 0;
        if (d_nxt != 0) m_ptr = d_nxt;
        if (d_off != 0) m_en = 0;
      end
      guard++;
    end while (!stop && guard < 3000);
  endtask

  task automatic check_write(input logic [31:0] a, input logic [1:0] s, input logic [31:0] d);
    if (wr_idx >= exp_n) begin
      chk(1'b0, "R6", "extra write", 32'(wr_idx + 1), 32'(exp_n));
    end else begin
      chk(a == exp_addr[wr_idx] && s == exp_size[wr_idx], "R4", "write addr",
          a, exp_addr[wr_idx]);
      chk(d == exp_data[wr_idx], "R5", "write data", d, exp_data[wr_idx]);
    end
    wr_idx++;
  endtask

  // memory responder
  initial begin
    logic [31:0] a, d;
    logic [1:0] s;
    bit w;
    forever begin
      @(negedge clk);
      req_ready = 1'b0;
      if (req_valid && rst_n) begin
        rsp_busy = 1;
        repeat ($urandom_range(0, 2)) @(negedge clk);
        req_ready = 1'b1;
        a = req_addr; w = req_write; s = req_size; d = req_wdata;
        @(negedge clk);
        req_ready = 1'b0;
        if (w) check_write(a, s, d);
        else begin
          repeat ($urandom_range(0, 2)) @(negedge clk);
          rsp_valid = 1'b1;
          rsp_rdata = (a < 32'd1024) ? dmem[a[9:2]] : hash(a);
          @(negedge clk);
          rsp_valid = 1'b0;
        end
        rsp_busy = 0;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (tr_out) tr_cnt++;
      if (irq) irq_cnt++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R6 watchdog: actual=hung expected=idle");
    summary();
    $finish;
  end

  task automatic wait_idle();
    int quiet = 0;
    while (quiet < 12) begin
      @(negedge clk);
      if (!req_valid && !rsp_busy) quiet++; else quiet = 0;
    end
  endtask

  task automatic enable(input logic [31:0] p);
    @(negedge clk); en_set = 1'b1; ptr = p;
    @(negedge clk); en_set = 1'b0;
    m_en = 1; m_dv = 0; m_ptr = p; m_x = 0; m_y = 0;
    @(negedge clk);
    chk(ch_en == 1'b1, "R12", "enable", 32'(ch_en), 1);
  endtask

  task automatic run_trig(input bit extra, input string tag);
    exp_n = 0; wr_idx = 0; exp_tr = 0; exp_irq = 0; tr_cnt = 0; irq_cnt = 0;
    model_trig();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    if (extra) begin // R10: second trigger while busy
      repeat (4) @(negedge clk);
      trig = 1'b1;
      @(negedge clk); trig = 1'b0;
    end
    wait_idle();
    chk(wr_idx == exp_n, "R6", {tag, " element count"}, 32'(wr_idx), 32'(exp_n));
    chk(tr_cnt == exp_tr, "R7", {tag, " trigger-out pulses"}, 32'(tr_cnt), 32'(exp_tr));
    chk(irq_cnt == exp_irq, "R7", {tag, " interrupt pulses"}, 32'(irq_cnt), 32'(exp_irq));
    chk(ch_en == m_en, "R9", {tag, " enable state"}, 32'(ch_en), 32'(m_en));
  endtask

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < 256; i++) dmem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!ch_en && !req_valid && !tr_out && !irq, "R1", "reset outputs",
        {28'd0, ch_en, req_valid, tr_out, irq}, 0);

    // FIFO-style 1D, descriptor per trigger, self-disable (R9), busy trigger ignored (R10)
    put_desc(0, 1, 0, 2, 0, 2, 1, 32'h2000, 32'h8000, 15, 1, 0, 0, 0, 0, 0);
    enable(0);
    run_trig(1, "R9 fifo");
    chk(ch_en == 1'b0, "R9", "disabled after descriptor", 32'(ch_en), 0);
    run_trig(0, "R10 disabled");

    // 2D, row per trigger, indices persist (R11)
    put_desc(64, 2, 2, 1, 1, 2, 0, 32'h3000, 32'h9000, 3, 1, 2, 2, 8, 16, 0);
    enable(64);
    for (int t = 0; t < 3; t++) run_trig(0, "R11 row");

    // chain single -> 2D, whole chain per trigger (R8, R2)
    put_desc(128, 0, 1, 3, 2, 3, 0, 32'h4000, 32'hA000, 0, 0, 0, 0, 0, 0, 32'd192);
    put_desc(192, 2, 0, 3, 2, 3, 0, 32'h4100, 32'hA100, 1, 3, 1, 1, 5, 7, 0);
    enable(128);
    run_trig(0, "R8 chain");
    run_trig(0, "R8 rerun");

    // element per trigger, half words (R6, R11)
    put_desc(256, 1, 1, 0, 0, 1, 0, 32'h5000, 32'hB000, 5, 2, 1, 0, 0, 0, 0);
    enable(256);
    for (int t = 0; t < 8; t++) run_trig(0, "R6 element");

    // circular chain (R8)
    put_desc(320, 1, 2, 2, 2, 0, 0, 32'h6000, 32'hC000, 2, 1, 1, 0, 0, 0, 32'd384);
    put_desc(384, 0, 0, 2, 1, 2, 0, 32'h6100, 32'hC100, 0, 0, 0, 0, 0, 0, 32'd320);
    enable(320);
    for (int t = 0; t < 3; t++) run_trig(0, "R8 circular");

    // random descriptors (R3 R4)
    for (int it = 0; it < 20; it++) begin
      put_desc(512, int'($urandom_range(0, 2)), int'($urandom_range(0, 2)),
               int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
               int'($urandom_range(0, 3)), int'($urandom_range(0, 1)),
               32'h10000 + 32'($urandom_range(0, 255)), 32'h20000 + 32'($urandom_range(0, 255)),
               int'($urandom_range(0, 4)), int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
               int'($urandom_range(0, 3)), int'($urandom_range(0, 7)), int'($urandom_range(0, 7)), 0);
      enable(512);
      for (int t = 0; t < 3; t++) run_trig(0, "R3 random");
    end

    summary();
    $finish;
  end
endmodule